// File: doc/BRIEF.md
# Prioritized Compute Queue Dispatcher

The dispatcher sits between software submitting compute queue descriptors and a set of eight asynchronous compute engines, each offering eight hardware queue slots. Descriptors enter through a valid/ready submit port carrying a queue identifier and a two-bit priority. They wait in a sixteen-entry pending store until some engine reports a free slot. Each cycle, the dispatcher then picks the most urgent pending descriptor and binds it to a slot.

The block tracks slot occupancy itself. A slot becomes busy when an assignment to it is issued. It becomes free again only when the release bit for that slot is pulsed. An assignment never displaces a queue that already holds a slot, so low-priority work that is already running keeps running beside newly placed urgent work. Assignments leave through a registered valid/ready port that carries the engine index, the slot index and the queue identifier.

Top module: `cq_dispatch`

## Requirements
- R1: After reset, `sub_ready` is 1 and `asg_valid` is 0, and all slots are free.
- R2: The pending store holds 16 descriptors. While 16 are pending, `sub_ready` is 0, and a descriptor offered in that state is not taken.
- R3: While no slot is free, pending descriptors stay buffered and no assignment is issued.
- R4: The pending descriptor with the numerically largest priority value is assigned first. Priority value 3 is the most urgent and 0 the least.
- R5: Among pending descriptors of equal priority, the one submitted earliest is assigned first.
- R6: The target is the lowest-numbered engine that has a free slot, and within that engine the lowest-numbered free slot. In `slot_release`, bit engine*8+slot stands for that slot.
- R7: A release pulse seen at clock edge t makes the slot usable for an assignment loaded at edge t+1 at the earliest. A release of a slot that is already free has no effect.
- R8: While `asg_valid` is 1 and `asg_ready` is 0, the assignment fields stay unchanged.
- R9: An occupied slot stays occupied until its own release bit is pulsed. A new assignment, whatever its priority, never evicts one.
- R10: A descriptor accepted at edge t, with a free slot and an empty output register, appears on the assignment port after edge t+1. At most one assignment is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Descriptor offered |
| sub_ready | output | 1 | Pending store has room |
| sub_prio | input | 2 | Descriptor priority, 3 most urgent |
| sub_qid | input | 8 | Queue identifier |
| slot_release | input | 64 | One pulse bit per slot, index engine*8+slot |
| asg_valid | output | 1 | Assignment available |
| asg_ready | input | 1 | Assignment accepted by consumer |
| asg_eng | output | 3 | Target engine index |
| asg_slot | output | 3 | Target slot within the engine |
| asg_qid | output | 8 | Identifier of the assigned queue |

## Verification
A descriptor that meets a free slot and an empty output register passes through two registers: the pending store at the accepting edge and the output register at the next edge. The bench therefore samples `asg_valid` low at the falling edge right after the submit edge, and high one falling edge later. A release pulse is likewise registered before the slot can be chosen. So after a release the bench expects `asg_valid` to be low at the first falling edge and the assignment to be present at the second. The bench drives all inputs and samples all outputs at falling edges, so each sample falls between the two register stages it depends on.

// File: rtl/cqd_pkg.sv
package cqd_pkg;
    localparam int PRIO_W = 2;
    localparam int QID_W  = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [QID_W-1:0]  qid_t;

    typedef struct packed {
        prio_t prio;
        qid_t  qid;
    } desc_t;
endpackage

// File: rtl/cqd_pend_buf.sv
module cqd_pend_buf import cqd_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  desc_t push_desc,
    input  logic  pop,
    output logic  space,
    output logic  has,
    output desc_t head
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        desc_t [DEPTH-1:0] ent;
        logic  [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [IDX_W-1:0] sel;
    logic             found;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        head  = '0;
        // entries are kept in arrival order; strict compare keeps the oldest
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < st_q.cnt && (!found || st_q.ent[i].prio > head.prio)) begin
                found = 1'b1;
                sel   = IDX_W'(i);
                head  = st_q.ent[i];
            end
        end

        st_d = st_q;
        if (pop && found) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= sel) st_d.ent[i] = st_q.ent[i+1];
            end
            st_d.ent[DEPTH-1] = '0;
            st_d.cnt          = st_q.cnt - CNT_W'(1);
        end
        if (push) begin
            st_d.ent[st_d.cnt[IDX_W-1:0]] = push_desc;
            st_d.cnt                      = st_d.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign space = (st_q.cnt != CNT_W'(DEPTH));
    assign has   = found;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R2
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> st_q.cnt < CNT_W'(DEPTH));
endmodule

// File: rtl/cqd_slot_map.sv
module cqd_slot_map #(
    parameter  int N_ENG  = 8,
    parameter  int N_SLOT = 8,
    localparam int TOT    = N_ENG * N_SLOT,
    localparam int IDX_W  = $clog2(TOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim,
    input  logic [TOT-1:0]   release_vec,
    output logic             any_free,
    output logic [IDX_W-1:0] pick
);
    typedef struct packed {
        logic [TOT-1:0] busy;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        any_free = 1'b0;
        pick     = '0;
        // flat index engine*N_SLOT+slot: lowest index = lowest engine, then slot
        for (int i = TOT - 1; i >= 0; i--) begin
            if (!st_q.busy[i]) begin
                any_free = 1'b1;
                pick     = IDX_W'(i);
            end
        end

        st_d.busy = st_q.busy & ~release_vec;
        if (claim) st_d.busy[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < TOT; g++) begin : g_slot_chk
        // R7
        release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
            release_vec[g] && !(claim && pick == IDX_W'(g)) |=> !st_q.busy[g]);

        // R9
        no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.busy[g] && !release_vec[g] |=> st_q.busy[g]);
    end
endmodule

// File: rtl/cq_dispatch.sv
module cq_dispatch import cqd_pkg::*; #(
    parameter int N_ENG  = 8,
    parameter int N_SLOT = 8,
    parameter int DEPTH  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sub_valid,
    output logic                      sub_ready,
    input  logic [PRIO_W-1:0]         sub_prio,
    input  logic [QID_W-1:0]          sub_qid,
    input  logic [N_ENG*N_SLOT-1:0]   slot_release,
    output logic                      asg_valid,
    input  logic                      asg_ready,
    output logic [$clog2(N_ENG)-1:0]  asg_eng,
    output logic [$clog2(N_SLOT)-1:0] asg_slot,
    output logic [QID_W-1:0]          asg_qid
);
    localparam int TOT    = N_ENG * N_SLOT;
    localparam int IDX_W  = $clog2(TOT);
    localparam int ENG_W  = $clog2(N_ENG);
    localparam int SLOT_W = $clog2(N_SLOT);

    typedef struct packed {
        logic              valid;
        logic [ENG_W-1:0]  eng;
        logic [SLOT_W-1:0] slot;
        qid_t              qid;
    } out_t;

    out_t             out_d, out_q;
    logic             push, load, space, has, any_free;
    desc_t            head;
    logic [IDX_W-1:0] pick;

    assign push = sub_valid && space;
    assign load = has && any_free && (!out_q.valid || asg_ready);

    cqd_pend_buf #(.DEPTH(DEPTH)) i_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_desc ({sub_prio, sub_qid}),
        .pop       (load),
        .space     (space),
        .has       (has),
        .head      (head)
    );

    cqd_slot_map #(.N_ENG(N_ENG), .N_SLOT(N_SLOT)) i_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .claim       (load),
        .release_vec (slot_release),
        .any_free    (any_free),
        .pick        (pick)
    );

    always_comb begin
        out_d = out_q;
        if (out_q.valid && asg_ready) out_d.valid = 1'b0;
        if (load) begin
            out_d.valid = 1'b1;
            out_d.eng   = ENG_W'(int'(pick) / N_SLOT);
            out_d.slot  = SLOT_W'(int'(pick) % N_SLOT);
            out_d.qid   = head.qid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sub_ready = space;
    assign asg_valid = out_q.valid;
    assign asg_eng   = out_q.eng;
    assign asg_slot  = out_q.slot;
    assign asg_qid   = out_q.qid;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asg_valid && !asg_ready |=> asg_valid && $stable(asg_eng)
            && $stable(asg_slot) && $stable(asg_qid));

    // R3
    no_blind_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_free |=> !asg_valid || $stable(asg_qid));
endmodule

// File: tb/test_cq_dispatch.sv
module test_cq_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int TOT        = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sub_valid = 1'b0;
    logic           sub_ready;
    logic [1:0]     sub_prio = '0;
    logic [7:0]     sub_qid = '0;
    logic [TOT-1:0] slot_release = '0;
    logic           asg_valid;
    logic           asg_ready = 1'b0;
    logic [2:0]     asg_eng;
    logic [2:0]     asg_slot;
    logic [7:0]     asg_qid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cq_dispatch i_cq_dispatch (
        .clk          (clk),
        .rst_n        (rst_n),
        .sub_valid    (sub_valid),
        .sub_ready    (sub_ready),
        .sub_prio     (sub_prio),
        .sub_qid      (sub_qid),
        .slot_release (slot_release),
        .asg_valid    (asg_valid),
        .asg_ready    (asg_ready),
        .asg_eng      (asg_eng),
        .asg_slot     (asg_slot),
        .asg_qid      (asg_qid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic submit(input int qid, input int prio);
        sub_valid = 1'b1;
        sub_qid   = 8'(qid);
        sub_prio  = 2'(prio);
        check("R2 ready", int'(sub_ready), 1);
        @(posedge clk);
        @(negedge clk);
        sub_valid = 1'b0;
    endtask

    task automatic take(input string req, input int flat, input int qid);
        for (int w = 0; w < 50 && !asg_valid; w++) @(negedge clk);
        check({req, " valid"}, int'(asg_valid), 1);
        check({req, " eng"},   int'(asg_eng),  flat / 8);
        check({req, " slot"},  int'(asg_slot), flat % 8);
        check({req, " qid"},   int'(asg_qid),  qid);
        asg_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        asg_ready = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int pr[16];
        int ord[16];
        int k;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 ready", int'(sub_ready), 1);
        check("R1 valid", int'(asg_valid), 0);

        // R6 R10: fill every slot in flat order
        for (int i = 0; i < TOT; i++) begin
            submit(i, i % 4);
            if (i == 0) begin
                check("R10 not before t+1", int'(asg_valid), 0);
                @(negedge clk);
                check("R10 at t+1", int'(asg_valid), 1);
                @(negedge clk);
                @(negedge clk);
                check("R8 eng", int'(asg_eng), 0);
                check("R8 slot", int'(asg_slot), 0);
                check("R8 qid", int'(asg_qid), 0);
            end
            take("R6 fill", i, i);
        end

        // R2 R3: all slots busy, fill pending store
        for (int j = 0; j < 16; j++) begin
            pr[j] = (j * 5 + 2) % 4;
            submit(100 + j, pr[j]);
        end
        check("R2 full", int'(sub_ready), 0);
        sub_valid = 1'b1;
        sub_qid   = 8'd200;
        sub_prio  = 2'd3;
        @(negedge clk);
        @(negedge clk);
        sub_valid = 1'b0;
        check("R2 still full", int'(sub_ready), 0);
        check("R3 held", int'(asg_valid), 0);

        // R4 R5 expected order: priority descending, then arrival
        k = 0;
        for (int p = 3; p >= 0; p--)
            for (int j = 0; j < 16; j++)
                if (pr[j] == p) begin
                    ord[k] = j;
                    k++;
                end

        // R7: release one slot, usable one edge later
        slot_release[43] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        slot_release = '0;
        check("R7 not same edge", int'(asg_valid), 0);
        @(negedge clk);
        check("R7 next edge", int'(asg_valid), 1);
        take("R4 first", 43, 100 + ord[0]);

        // R9: no eviction of running slots
        repeat (5) @(negedge clk);
        check("R9 no evict", int'(asg_valid), 0);
        check("R2 room again", int'(sub_ready), 1);

        slot_release = '1;
        @(posedge clk);
        @(negedge clk);
        slot_release = '0;
        for (int m = 1; m < 16; m++) take("R5 order", m - 1, 100 + ord[m]);
        repeat (3) @(negedge clk);
        check("R2 rejected offer absent", int'(asg_valid), 0);

        // R7: releasing a free slot changes nothing, busy slot 5 freed
        slot_release[5]  = 1'b1;
        slot_release[63] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        slot_release = '0;
        submit(77, 0);
        take("R7 freed slot", 5, 77);
        submit(78, 1);
        take("R7 free release ignored", 15, 78);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule